// File: doc/BRIEF.md
# Windowed Sensor Readout Timing Generator

This block produces the frame, line and pixel strobes for scanning a rectangular window of an image array. Every frame starts with a frame overhead interval. The length of that interval comes from a 2-bit granularity code. Each line of the window then gets a row overhead interval followed by one clock per pixel. While a pixel is valid, the current column and row addresses are presented alongside it.

Software loads a set of values into ordinary configuration inputs: the granularity code, a subsampling enable, the window origin, the pixels per line and the lines per frame. The generator copies these inputs into shadow registers only when a frame overhead begins. A frame already in progress therefore always finishes with the settings it started with. Column addresses are kept on 8-pixel boundaries. In subsampling mode, rows advance two at a time, and each row overhead is 8 cycles longer.

Top module: `win_readout_timer`

## Requirements
- R1: After reset or after the last pixel of a frame, frame_valid stays low for the frame overhead: 192, 336, 624 or 1200 cycles for granularity code 0, 1, 2 or 3.
- R2: Each line begins with a row overhead with frame_valid high and line_valid low. It lasts 20, 24, 32 or 48 cycles for granularity code 0, 1, 2 or 3.
- R3: With subsampling enabled, every row overhead is 8 cycles longer than the R2 value.
- R4: A line holds 8 × win_pix_groups pixels, and a value of 0 counts as 1 group. pixel_valid is high for exactly one cycle per pixel, and only while line_valid is high.
- R5: A frame holds win_lines lines, and a value of 0 counts as 1 line. The frame period equals the frame overhead plus, for every line, the row overhead plus the pixel count.
- R6: The first pixel of each line has x_addr = 8 × win_x_start, so its low 3 bits are 0. Each following pixel of the line increments x_addr by 1, modulo 2^XW.
- R7: During line k (counting from 0), y_addr equals win_y_start + k in normal mode. In subsampling mode it equals win_y_start with bit 0 cleared, plus 2k. The value wraps modulo 2^YW and does not change within a line.
- R8: All configuration inputs are sampled at the reset edge and at the edge that ends the last pixel of a frame. A change at any other time has no effect until the next frame overhead.
- R9: A synchronous active-high reset makes frame_valid, line_valid and pixel_valid low in the next cycle and starts a full frame overhead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gran_sel | input | 2 | Granularity code selecting the overhead lengths |
| subsample_en | input | 1 | Subsampling mode: two-row steps, longer row overhead |
| win_x_start | input | XW-3 | Window column origin in 8-pixel units |
| win_y_start | input | YW | Window row origin |
| win_pix_groups | input | XW-2 | Pixels per line in groups of 8 (0 means 1) |
| win_lines | input | YW+1 | Lines per frame (0 means 1) |
| frame_valid | output | 1 | High from the first row overhead to the last pixel |
| line_valid | output | 1 | High during the pixels of a line |
| pixel_valid | output | 1 | One pulse per pixel |
| x_addr | output | XW | Column address of the current pixel |
| y_addr | output | YW | Row address of the current line |

## Verification
Nearly every fault inside this generator shows up as a miscount, and a miscount is visible at the ports within one frame.

If the shared counter ends a phase at the wrong value, the width of a frame_valid-low or line_valid-low interval is off as soon as that phase closes. If the line index or the shadow copy is corrupted, y_addr on the next rising edge of line_valid is wrong, or the total frame period is wrong at the next falling edge of frame_valid.

The bench measures every interval in cycles and compares it with the requirement formulas. It also compares addresses on every line.

// File: rtl/win_readout_timer.sv
module win_readout_timer #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    gran_sel,
  input  logic          subsample_en,
  input  logic [XW-4:0] win_x_start,
  input  logic [YW-1:0] win_y_start,
  input  logic [XW-3:0] win_pix_groups,
  input  logic [YW:0]   win_lines,
  output logic          frame_valid,
  output logic          line_valid,
  output logic          pixel_valid,
  output logic [XW-1:0] x_addr,
  output logic [YW-1:0] y_addr
);
  localparam int CW = (XW + 2 > 11) ? XW + 2 : 11;
  localparam int LW = YW + 1;

  typedef enum logic [1:0] {PH_FOH, PH_ROH, PH_PIX} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [LW-1:0] line_idx;

  logic [1:0]    s_gran;
  logic          s_sub;
  logic [XW-4:0] s_xs;
  logic [YW-1:0] s_ys;
  logic [XW-3:0] s_pg;
  logic [LW-1:0] s_ln;

  logic [CW-1:0] foh_len, roh_len, pix_len;
  logic [LW-1:0] line_len;

  always_comb begin
    case (s_gran)
      2'd0:    foh_len = CW'(192);
      2'd1:    foh_len = CW'(336);
      2'd2:    foh_len = CW'(624);
      default: foh_len = CW'(1200);
    endcase
    case (s_gran)
      2'd0:    roh_len = CW'(20);
      2'd1:    roh_len = CW'(24);
      2'd2:    roh_len = CW'(32);
      default: roh_len = CW'(48);
    endcase
    if (s_sub) roh_len = roh_len + CW'(8);
  end

  assign pix_len  = (s_pg == '0) ? CW'(8) : {{(CW-XW-1){1'b0}}, s_pg, 3'b000};
  assign line_len = (s_ln == '0) ? LW'(1) : s_ln;

  wire foh_done  = (phase == PH_FOH) && (cnt == foh_len - CW'(1));
  wire roh_done  = (phase == PH_ROH) && (cnt == roh_len - CW'(1));
  wire pix_done  = (phase == PH_PIX) && (cnt == pix_len - CW'(1));
  wire last_line = (line_idx == line_len - LW'(1));
  wire reload    = rst || (pix_done && last_line);

  always_ff @(posedge clk) begin
    if (reload) begin
      s_gran <= gran_sel;
      s_sub  <= subsample_en;
      s_xs   <= win_x_start;
      s_ys   <= win_y_start;
      s_pg   <= win_pix_groups;
      s_ln   <= win_lines;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_FOH;
      cnt      <= '0;
      line_idx <= '0;
    end else if (foh_done) begin
      phase <= PH_ROH;
      cnt   <= '0;
    end else if (roh_done) begin
      phase <= PH_PIX;
      cnt   <= '0;
    end else if (pix_done) begin
      cnt <= '0;
      if (last_line) begin
        phase    <= PH_FOH;
        line_idx <= '0;
      end else begin
        phase    <= PH_ROH;
        line_idx <= line_idx + LW'(1);
      end
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  wire [YW-1:0] y_base = s_sub ? {s_ys[YW-1:1], 1'b0} : s_ys;
  wire [YW-1:0] y_off  = s_sub ? YW'({line_idx, 1'b0}) : line_idx[YW-1:0];

  assign frame_valid = (phase != PH_FOH);
  assign line_valid  = (phase == PH_PIX);
  assign pixel_valid = (phase == PH_PIX);
  assign x_addr      = {s_xs, 3'b000} + (line_valid ? cnt[XW-1:0] : '0);
  assign y_addr      = y_base + y_off;
endmodule

module win_readout_timer_chk #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          fv,
  input logic          lv,
  input logic          pv,
  input logic [XW-1:0] x,
  input logic [YW-1:0] y
);
  // R4
  pix_in_line_chk: assert property (@(posedge clk) disable iff (rst) pv |-> lv);
  // R2
  line_in_frame_chk: assert property (@(posedge clk) disable iff (rst) lv |-> fv);
  // R2
  frame_opens_overhead_chk: assert property (@(posedge clk) disable iff (rst) $rose(fv) |-> !lv);
  // R9
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!fv && !lv && !pv));
  // R6
  x_step_chk: assert property (@(posedge clk) disable iff (rst)
    (lv && $past(lv) && !$past(rst)) |-> (x == $past(x) + XW'(1)));
  // R6
  x_aligned_chk: assert property (@(posedge clk) disable iff (rst) $rose(lv) |-> (x[2:0] == 3'b000));
  // R7
  y_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lv && $past(lv) && !$past(rst)) |-> $stable(y));
endmodule

bind win_readout_timer win_readout_timer_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst(rst), .fv(frame_valid), .lv(line_valid),
  .pv(pixel_valid), .x(x_addr), .y(y_addr)
);

// File: tb/tb_win_readout_timer.sv
module tb_win_readout_timer;
  localparam int XW = 10;
  localparam int YW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    gran_sel = '0;
  logic          subsample_en = 1'b0;
  logic [XW-4:0] win_x_start = '0;
  logic [YW-1:0] win_y_start = '0;
  logic [XW-3:0] win_pix_groups = '0;
  logic [YW:0]   win_lines = '0;
  logic          frame_valid, line_valid, pixel_valid;
  logic [XW-1:0] x_addr;
  logic [YW-1:0] y_addr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  win_readout_timer #(.XW(XW), .YW(YW)) dut (.*);

  // gran, sub, xs, ys, pix_groups, lines, exp_foh, exp_roh, exp_period
  localparam int NV = 5;
  localparam int VEC [NV][9] = '{
    '{0, 0,   2,   5, 1, 3,  192, 20,  276},
    '{1, 1,   0,   7, 2, 2,  336, 32,  432},
    '{2, 0, 120, 500, 1, 4,  624, 32,  784},
    '{3, 1,   4,  10, 0, 0, 1200, 56, 1264},
    '{3, 0,   1,   0, 3, 2, 1200, 48, 1344}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply_cfg(input int v[9]);
    gran_sel       = v[0][1:0];
    subsample_en   = v[1][0];
    win_x_start    = v[2][XW-4:0];
    win_y_start    = v[3][YW-1:0];
    win_pix_groups = v[4][XW-3:0];
    win_lines      = v[5][YW:0];
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  // Measures one frame starting at the current sample (must be in frame overhead)
  task automatic check_frame(input int v[9]);
    int foh = 0, body = 0, roh1 = 0, pix1 = 0, nl = 0, x0 = -1;
    int xerr = 0, yerr = 0, pverr = 0, lastx = 0;
    int ysq, stp, epix, eln;
    logic prev_lv = 1'b0, seen = 1'b0;
    epix = (v[4] == 0) ? 8 : v[4] * 8;
    eln  = (v[5] == 0) ? 1 : v[5];
    ysq  = v[1] ? (v[3] & ~1) : v[3];
    stp  = v[1] ? 2 : 1;
    for (int i = 0; i < 20000; i++) begin
      if (!frame_valid) begin
        if (seen) break;
        foh++;
      end else begin
        seen = 1'b1;
        body++;
        if (line_valid) begin
          if (!prev_lv) begin
            if (int'(y_addr) != (ysq + nl * stp) % (1 << YW)) yerr++;
            nl++;
            if (nl == 1) x0 = int'(x_addr);
          end else if (int'(x_addr) != (lastx + 1) % (1 << XW)) xerr++;
          lastx = int'(x_addr);
          if (nl == 1) pix1++;
          if (!pixel_valid) pverr++;
        end else if (nl == 0) roh1++;
      end
      prev_lv = line_valid;
      step();
    end
    chk("R1", "frame overhead", foh, v[6]);
    chk(v[1] ? "R3" : "R2", "row overhead", roh1, v[7]);
    chk("R4", "pixels per line", pix1, epix);
    chk("R4", "pixel_valid gaps", pverr, 0);
    chk("R5", "lines per frame", nl, eln);
    chk("R5", "frame period", foh + body, v[8]);
    chk("R6", "first x", x0, (v[2] * 8) % (1 << XW));
    chk("R6", "x step errors", xerr, 0);
    chk("R7", "y errors", yerr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    apply_cfg(VEC[0]);
    do_reset();
    // R9 reset state
    chk("R9", "frame_valid after reset", int'(frame_valid), 0);
    chk("R9", "line_valid after reset", int'(line_valid), 0);
    chk("R9", "pixel_valid after reset", int'(pixel_valid), 0);

    for (int k = 0; k < NV; k++) begin
      apply_cfg(VEC[k]);
      do_reset();
      check_frame(VEC[k]);
    end

    // R8: config changed right after the reset edge; frame keeps old values
    apply_cfg(VEC[0]);
    rst = 1'b1;
    step();
    rst = 1'b0;
    apply_cfg(VEC[4]);
    check_frame(VEC[0]);
    // R8: next frame picks up the new settings
    check_frame(VEC[4]);

    // R8: change in the middle of a line has no effect on the current frame
    apply_cfg(VEC[1]);
    do_reset();
    while (!line_valid) step();
    apply_cfg(VEC[2]);
    begin
      int rest = 0, nl = 0;
      logic plv = 1'b1;
      while (frame_valid) begin
        if (line_valid && !plv) begin
          nl++;
          chk("R8", "y keeps old step", int'(y_addr), 6 + 2 * nl);
        end
        plv = line_valid;
        rest++;
        step();
      end
      chk("R8", "remaining cycles of frame", rest, 16 + 32 + 16);
    end
    check_frame(VEC[2]);

    // R9: reset in the middle of a line
    apply_cfg(VEC[0]);
    do_reset();
    while (!line_valid) step();
    step();
    rst = 1'b1;
    step();
    chk("R9", "valids low after mid-line reset",
        int'({frame_valid, line_valid, pixel_valid}), 0);
    rst = 1'b0;
    check_frame(VEC[0]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule